// File: doc/BRIEF.md
# Invalidation Queue Descriptor Engine

This engine lives inside an I/O address-translation unit and drains invalidation work that software places in a circular ring in memory. The ring is 4096 bytes long and holds 256 descriptors of 16 bytes each. Software fills descriptors, then publishes them by moving a tail offset. While the ring is switched on, the engine fetches the descriptor at its head offset over a 128-bit read port and decodes it. A context-cache request goes out on a cache-invalidate port. A translation-lookaside request goes out on a TLB-invalidate port. A wait descriptor may store a 32-bit completion word to a memory address that software supplies. The head offset moves on only once the action has been handed off.

The ring is switched on and off with a command bit, and an echo status bit follows it. Software polls the status bit after it changes the command. Switching off returns head and tail to zero and clears the error flag. A malformed descriptor stops the engine with head left on the faulty entry.

Every data-carrying port uses valid/ready. The engine keeps a request's valid high, with its payload unchanged, until the consumer asserts ready in the same cycle. The transfer happens on the clock edge where both are high. Only one request is outstanding at a time. Read responses must arrive as a single-cycle `rsp_valid` pulse, and the engine always accepts them.

Top module: `invq_engine`

## Requirements
- R1: `qen_sts` rises on the edge after `qen_cmd` is seen high. It falls on the first edge where `qen_cmd` is low and the engine is idle or halted. On that same edge, head, tail and `err_flag` return to 0.
- R2: A `tail_we` pulse while `qen_sts` is 0 has no effect. While on, `tail_wdata` with bits 3:0 forced to 0 becomes the tail. Only a tail that differs from head starts work.
- R3: Each fetch is a single read at address `qbase + head`, where head is a byte offset. The 128-bit response supplies the lower word in bits 63:0 and the upper word in bits 127:64.
- R4: A lower-word type field (bits 3:0) of 1 with scope (bits 5:4) nonzero is a context-cache request. The port carries scope = bits 5:4, domain = bits 31:16, source = bits 47:32 and mask = bits 49:48.
- R5: A type of 2 with nonzero scope is a TLB request. The port carries scope = bits 5:4, domain = bits 31:16, drain-reads = bit 7, drain-writes = bit 6 and the whole upper word on `tlb_page`.
- R6: A type of 5 with lower bit 5 set writes lower bits 63:32 to the address in the upper word. A type of 5 with bit 5 clear issues no write and only advances head.
- R7: Descriptors are handled strictly in ring order. Head advances by 16, wrapping modulo 4096, only on the handshake of the current action. No more than one request valid is high in any cycle.
- R8: A type other than 1, 2 or 5, or scope 0 on type 1 or 2, sets a sticky `err_flag`. The engine then halts with head on the faulty entry and issues no further requests until it is switched off.
- R9: A request valid that sees ready low stays high on the next cycle with an unchanged payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qbase | input | AW | Ring base address, 4096-byte aligned |
| qen_cmd | input | 1 | Ring enable command |
| qen_sts | output | 1 | Ring enabled status |
| tail_we | input | 1 | Tail write strobe |
| tail_wdata | input | PW | New tail byte offset |
| head_ptr | output | PW | Current head byte offset |
| err_flag | output | 1 | Sticky malformed-descriptor flag |
| rd_valid | output | 1 | Descriptor read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 128 | Descriptor, upper word in 127:64 |
| wr_valid | output | 1 | Status write request valid |
| wr_ready | input | 1 | Status write accepted |
| wr_addr | output | AW | Status write address |
| wr_data | output | 32 | Status word |
| cc_valid | output | 1 | Context-cache invalidate valid |
| cc_ready | input | 1 | Context-cache invalidate accepted |
| cc_gran | output | 2 | Scope: 1 global, 2 domain, 3 device |
| cc_did | output | 16 | Domain identifier |
| cc_sid | output | 16 | Source identifier |
| cc_fm | output | 2 | Function mask |
| tlb_valid | output | 1 | TLB invalidate valid |
| tlb_ready | input | 1 | TLB invalidate accepted |
| tlb_gran | output | 2 | Scope: 1 global, 2 domain, 3 page |
| tlb_did | output | 16 | Domain identifier |
| tlb_drain_rd | output | 1 | Drain reads request |
| tlb_drain_wr | output | 1 | Drain writes request |
| tlb_page | output | 64 | Page address, mask and hint word |

## Verification
The assertions check several properties on every cycle. Held requests stay stable under back-pressure. At most one request is valid at a time. Head stays 16-byte aligned and only ever steps by exactly 16. Head is zero whenever the ring is off. The engine is silent and head frozen while in error. The directed scenarios cover what depends on memory contents. These include the field extraction for each descriptor type and the wait write versus skip. They also include the ignored tail write while off, the wrap from entry 255 to 0, and halting on a bad type or a zero scope.

// File: rtl/invq_pkg.sv
package invq_pkg;
  localparam logic [3:0] TYPE_CTX  = 4'h1;
  localparam logic [3:0] TYPE_TLB  = 4'h2;
  localparam logic [3:0] TYPE_WAIT = 4'h5;

  typedef enum logic [2:0] {
    K_CTX,
    K_TLB,
    K_WSTAT,
    K_WSKIP,
    K_BAD
  } kind_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_RESP,
    S_ACT,
    S_HALT
  } st_t;
endpackage

// File: rtl/invq_ctrl.sv
module invq_ctrl #(
  parameter int PW  = 12,
  parameter int LSB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          qen_cmd,
  input  logic          quiet,
  input  logic          tail_we,
  input  logic [PW-1:0] tail_wdata,
  output logic          sts,
  output logic          off_go,
  output logic [PW-1:0] tail
);
  logic [LSB-1:0] unused_low;
  assign unused_low = tail_wdata[LSB-1:0];

  assign off_go = sts && !qen_cmd && quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts  <= 1'b0;
      tail <= '0;
    end else if (!sts) begin
      if (qen_cmd) sts <= 1'b1;
    end else if (off_go) begin
      sts  <= 1'b0;
      tail <= '0;
    end else if (tail_we) begin
      tail <= {tail_wdata[PW-1:LSB], {LSB{1'b0}}};
    end
  end
endmodule

// File: rtl/invq_decode.sv
module invq_decode
  import invq_pkg::*;
(
  input  logic [63:0] lo,
  output kind_t       kind,
  output logic [1:0]  gran,
  output logic [15:0] did,
  output logic [15:0] sid,
  output logic [1:0]  fm,
  output logic        drain_rd,
  output logic        drain_wr,
  output logic [31:0] stat_data
);
  logic [7:0] unused_mid;
  assign unused_mid = lo[15:8];

  assign gran      = lo[5:4];
  assign did       = lo[31:16];
  assign sid       = lo[47:32];
  assign fm        = lo[49:48];
  assign drain_rd  = lo[7];
  assign drain_wr  = lo[6];
  assign stat_data = lo[63:32];

  always_comb begin
    unique case (lo[3:0])
      TYPE_CTX:  kind = (lo[5:4] == 2'd0) ? K_BAD : K_CTX;
      TYPE_TLB:  kind = (lo[5:4] == 2'd0) ? K_BAD : K_TLB;
      TYPE_WAIT: kind = lo[5] ? K_WSTAT : K_WSKIP;
      default:   kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/invq_engine.sv
module invq_engine
  import invq_pkg::*;
#(
  parameter int QBYTES = 4096,
  parameter int DBYTES = 16,
  parameter int AW     = 64,
  localparam int PW    = $clog2(QBYTES),
  localparam int LSB   = $clog2(DBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] qbase,
  input  logic          qen_cmd,
  output logic          qen_sts,
  input  logic          tail_we,
  input  logic [PW-1:0] tail_wdata,
  output logic [PW-1:0] head_ptr,
  output logic          err_flag,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  input  logic [127:0]  rsp_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          cc_valid,
  input  logic          cc_ready,
  output logic [1:0]    cc_gran,
  output logic [15:0]   cc_did,
  output logic [15:0]   cc_sid,
  output logic [1:0]    cc_fm,
  output logic          tlb_valid,
  input  logic          tlb_ready,
  output logic [1:0]    tlb_gran,
  output logic [15:0]   tlb_did,
  output logic          tlb_drain_rd,
  output logic          tlb_drain_wr,
  output logic [63:0]   tlb_page
);
  st_t           state;
  logic [PW-1:0] head;
  logic [PW-1:0] tail;
  logic          err_q;
  logic [63:0]   desc_lo;
  logic [63:0]   desc_hi;
  logic          off_go;
  logic          quiet;
  logic          act_done;
  kind_t         kind;
  logic [1:0]    f_gran;
  logic [15:0]   f_did;
  logic [15:0]   f_sid;
  logic [1:0]    f_fm;
  logic          f_drd;
  logic          f_dwr;
  logic [31:0]   f_stat;

  assign quiet = (state == S_IDLE) || (state == S_HALT);

  invq_ctrl #(.PW(PW), .LSB(LSB)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .qen_cmd    (qen_cmd),
    .quiet      (quiet),
    .tail_we    (tail_we),
    .tail_wdata (tail_wdata),
    .sts        (qen_sts),
    .off_go     (off_go),
    .tail       (tail)
  );

  invq_decode dec_i (
    .lo        (desc_lo),
    .kind      (kind),
    .gran      (f_gran),
    .did       (f_did),
    .sid       (f_sid),
    .fm        (f_fm),
    .drain_rd  (f_drd),
    .drain_wr  (f_dwr),
    .stat_data (f_stat)
  );

  always_comb begin
    unique case (kind)
      K_CTX:   act_done = cc_ready;
      K_TLB:   act_done = tlb_ready;
      K_WSTAT: act_done = wr_ready;
      K_WSKIP: act_done = 1'b1;
      default: act_done = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      head    <= '0;
      err_q   <= 1'b0;
      desc_lo <= '0;
      desc_hi <= '0;
    end else if (off_go) begin
      state <= S_IDLE;
      head  <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE:  if (qen_sts && (head != tail)) state <= S_FETCH;
        S_FETCH: if (rd_ready) state <= S_RESP;
        S_RESP: begin
          if (rsp_valid) begin
            desc_lo <= rsp_data[63:0];
            desc_hi <= rsp_data[127:64];
            state   <= S_ACT;
          end
        end
        S_ACT: begin
          if (kind == K_BAD) begin
            err_q <= 1'b1;
            state <= S_HALT;
          end else if (act_done) begin
            head  <= head + PW'(DBYTES);
            state <= S_IDLE;
          end
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assign head_ptr = head;
  assign err_flag = err_q;

  assign rd_valid = (state == S_FETCH);
  assign rd_addr  = qbase + AW'(head);

  assign wr_valid = (state == S_ACT) && (kind == K_WSTAT);
  assign wr_addr  = desc_hi[AW-1:0];
  assign wr_data  = f_stat;

  assign cc_valid = (state == S_ACT) && (kind == K_CTX);
  assign cc_gran  = f_gran;
  assign cc_did   = f_did;
  assign cc_sid   = f_sid;
  assign cc_fm    = f_fm;

  assign tlb_valid    = (state == S_ACT) && (kind == K_TLB);
  assign tlb_gran     = f_gran;
  assign tlb_did      = f_did;
  assign tlb_drain_rd = f_drd;
  assign tlb_drain_wr = f_dwr;
  assign tlb_page     = desc_hi;
endmodule

// File: rtl/invq_engine_chk.sv
module invq_engine_chk #(
  parameter int PW = 12,
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          qen_cmd,
  input logic          qen_sts,
  input logic [PW-1:0] head_ptr,
  input logic          err_flag,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic          cc_valid,
  input logic          cc_ready,
  input logic [1:0]    cc_gran,
  input logic [15:0]   cc_did,
  input logic [15:0]   cc_sid,
  input logic [1:0]    cc_fm,
  input logic          tlb_valid,
  input logic          tlb_ready,
  input logic [1:0]    tlb_gran,
  input logic [15:0]   tlb_did,
  input logic [63:0]   tlb_page
);
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  a_r9_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cc_valid && !cc_ready |=> cc_valid && $stable({cc_gran, cc_did, cc_sid, cc_fm}));

  a_r9_tlb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_valid && !tlb_ready |=> tlb_valid && $stable({tlb_gran, tlb_did, tlb_page}));

  a_r7_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, wr_valid, cc_valid, tlb_valid}));

  a_r7_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    qen_sts && !$stable(head_ptr) |-> head_ptr == $past(head_ptr) + PW'(16));

  a_r2_head_align: assert property (@(posedge clk) disable iff (!rst_n)
    head_ptr[3:0] == 4'd0);

  a_r1_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !qen_sts |-> head_ptr == '0 && !err_flag);

  a_r1_rise_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qen_sts) |-> $past(qen_cmd));

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> !(rd_valid || wr_valid || cc_valid || tlb_valid));

  a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && qen_cmd |=> err_flag && $stable(head_ptr));
endmodule

bind invq_engine invq_engine_chk #(.PW(PW), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .qen_cmd   (qen_cmd),
  .qen_sts   (qen_sts),
  .head_ptr  (head_ptr),
  .err_flag  (err_flag),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .cc_valid  (cc_valid),
  .cc_ready  (cc_ready),
  .cc_gran   (cc_gran),
  .cc_did    (cc_did),
  .cc_sid    (cc_sid),
  .cc_fm     (cc_fm),
  .tlb_valid (tlb_valid),
  .tlb_ready (tlb_ready),
  .tlb_gran  (tlb_gran),
  .tlb_did   (tlb_did),
  .tlb_page  (tlb_page)
);

// File: tb/invq_engine_tb_top.sv
`timescale 1ns/1ps
module invq_engine_tb_top;
  localparam logic [63:0] QB = 64'h0000_0001_0000_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         qen_cmd = 1'b0;
  logic         tail_we = 1'b0;
  logic [11:0]  tail_wdata = '0;
  logic         rd_ready = 1'b1;
  logic         wr_ready = 1'b1;
  logic         cc_ready = 1'b1;
  logic         tlb_ready = 1'b1;
  logic         rsp_valid = 1'b0;
  logic [127:0] rsp_data = '0;
  logic         qen_sts, err_flag;
  logic [11:0]  head_ptr;
  logic         rd_valid, wr_valid, cc_valid, tlb_valid;
  logic [63:0]  rd_addr, wr_addr, tlb_page;
  logic [31:0]  wr_data;
  logic [1:0]   cc_gran, cc_fm, tlb_gran;
  logic [15:0]  cc_did, cc_sid, tlb_did;
  logic         tlb_drain_rd, tlb_drain_wr;

  invq_engine dut_i (
    .clk(clk), .rst_n(rst_n), .qbase(QB), .qen_cmd(qen_cmd), .qen_sts(qen_sts),
    .tail_we(tail_we), .tail_wdata(tail_wdata), .head_ptr(head_ptr), .err_flag(err_flag),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .cc_valid(cc_valid), .cc_ready(cc_ready), .cc_gran(cc_gran), .cc_did(cc_did),
    .cc_sid(cc_sid), .cc_fm(cc_fm),
    .tlb_valid(tlb_valid), .tlb_ready(tlb_ready), .tlb_gran(tlb_gran), .tlb_did(tlb_did),
    .tlb_drain_rd(tlb_drain_rd), .tlb_drain_wr(tlb_drain_wr), .tlb_page(tlb_page)
  );

  logic [127:0] mem [256];
  int unsigned  cc_cnt = 0, tlb_cnt = 0, wr_cnt = 0;
  logic [63:0]  last_rd, last_wa;
  logic [31:0]  last_wd;
  logic [1:0]   l_cgran, l_cfm, l_tgran;
  logic [15:0]  l_cdid, l_csid, l_tdid;
  logic         l_drd, l_dwr;
  logic [63:0]  l_tpage;

  always @(posedge clk) begin
    rsp_valid <= rd_valid && rd_ready;
    rsp_data  <= mem[8'((rd_addr - QB) >> 4)];
    if (rd_valid && rd_ready) last_rd <= rd_addr;
    if (cc_valid && cc_ready) begin
      cc_cnt <= cc_cnt + 1;
      l_cgran <= cc_gran; l_cdid <= cc_did; l_csid <= cc_sid; l_cfm <= cc_fm;
    end
    if (tlb_valid && tlb_ready) begin
      tlb_cnt <= tlb_cnt + 1;
      l_tgran <= tlb_gran; l_tdid <= tlb_did; l_drd <= tlb_drain_rd;
      l_dwr <= tlb_drain_wr; l_tpage <= tlb_page;
    end
    if (wr_valid && wr_ready) begin
      wr_cnt <= wr_cnt + 1; last_wa <= wr_addr; last_wd <= wr_data;
    end
  end

  int n_run = 0, n_fail = 0;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put_tail(input logic [11:0] v);
    @(negedge clk); tail_we = 1'b1; tail_wdata = v;
    @(negedge clk); tail_we = 1'b0;
  endtask

  task automatic wait_head(input logic [11:0] v, input int lim);
    for (int i = 0; i < lim && head_ptr !== v; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 sts after reset", qen_sts, 1'b0);
    check("R1 head after reset", head_ptr, 12'd0);
    check("R8 err after reset", err_flag, 1'b0);
    check("R7 no request after reset", {rd_valid, wr_valid, cc_valid, tlb_valid}, 4'd0);
  endtask

  task automatic t_enable_ignore;
    int unsigned c0;
    c0 = cc_cnt;
    put_tail(12'd32);
    @(negedge clk); qen_cmd = 1'b1;
    @(negedge clk);
    check("R1 sts one cycle after cmd", qen_sts, 1'b1);
    cycles(10);
    check("R2 tail write while off ignored: head", head_ptr, 12'd0);
    check("R2 tail write while off ignored: no cc", cc_cnt - c0, 0);
  endtask

  task automatic t_ctx;
    mem[0] = {64'd0, 14'd0, 2'd2, 16'hBEEF, 16'h1234, 8'd0, 2'd0, 2'd3, 4'h1};
    put_tail(12'd16);
    wait_head(12'd16, 50);
    check("R7 head after ctx", head_ptr, 12'd16);
    check("R3 fetch addr", last_rd, QB);
    check("R4 ctx gran", l_cgran, 2'd3);
    check("R4 ctx did", l_cdid, 16'h1234);
    check("R4 ctx sid", l_csid, 16'hBEEF);
    check("R4 ctx fm", l_cfm, 2'd2);
  endtask

  task automatic t_tlb_stall;
    mem[1] = {64'h0000_1234_5678_9041, 32'd0, 16'h00AB, 8'd0, 2'b10, 2'd3, 4'h2};
    tlb_ready = 1'b0;
    put_tail(12'd32);
    cycles(10);
    check("R7 head held while tlb stalled", head_ptr, 12'd16);
    check("R9 tlb valid held", tlb_valid, 1'b1);
    tlb_ready = 1'b1;
    wait_head(12'd32, 50);
    check("R7 head after tlb", head_ptr, 12'd32);
    check("R3 fetch addr second", last_rd, QB + 64'd16);
    check("R5 tlb gran", l_tgran, 2'd3);
    check("R5 tlb did", l_tdid, 16'h00AB);
    check("R5 tlb drains", {l_drd, l_dwr}, 2'b10);
    check("R5 tlb page word", l_tpage, 64'h0000_1234_5678_9041);
  endtask

  task automatic t_wait;
    int unsigned w0;
    w0 = wr_cnt;
    mem[2] = {64'h0000_0000_8000_0040, 32'hCAFE_0001, 24'd0, 8'h25};
    mem[3] = {64'h0000_0000_9000_0000, 32'h1111_2222, 24'd0, 8'h05};
    put_tail(12'd64);
    wait_head(12'd64, 80);
    check("R6 head after waits", head_ptr, 12'd64);
    check("R6 one status write only", wr_cnt - w0, 1);
    check("R6 status addr", last_wa, 64'h8000_0040);
    check("R6 status data", last_wd, 32'hCAFE_0001);
  endtask

  task automatic t_wrap;
    int unsigned c0;
    c0 = cc_cnt;
    put_tail(12'd4080);
    wait_head(12'd4080, 3000);
    put_tail(12'd16);
    wait_head(12'd16, 100);
    check("R2 head after wrap", head_ptr, 12'd16);
    check("R7 in-order count across wrap", cc_cnt - c0, 253);
  endtask

  task automatic t_bad_type;
    int unsigned c0;
    c0 = cc_cnt;
    mem[1] = {64'd0, 64'h7};
    put_tail(12'd32);
    cycles(20);
    check("R8 err on bad type", err_flag, 1'b1);
    check("R8 head on bad entry", head_ptr, 12'd16);
    put_tail(12'd48);
    cycles(20);
    check("R8 halted head", head_ptr, 12'd16);
    check("R8 no request when halted", cc_cnt - c0, 0);
  endtask

  task automatic t_disable;
    int unsigned c0;
    @(negedge clk); qen_cmd = 1'b0;
    @(negedge clk);
    check("R1 sts falls", qen_sts, 1'b0);
    check("R1 head cleared", head_ptr, 12'd0);
    check("R1 err cleared", err_flag, 1'b0);
    c0 = cc_cnt;
    put_tail(12'd16);
    @(negedge clk); qen_cmd = 1'b1;
    cycles(20);
    check("R2 off tail write ignored after re-enable", head_ptr, 12'd0);
    check("R2 no work without new tail", cc_cnt - c0, 0);
  endtask

  task automatic t_zero_scope;
    int unsigned c0;
    c0 = cc_cnt;
    mem[0] = {64'd0, 64'h1};
    put_tail(12'd16);
    cycles(20);
    check("R8 err on zero scope", err_flag, 1'b1);
    check("R8 head on zero-scope entry", head_ptr, 12'd0);
    check("R8 zero scope not forwarded", cc_cnt - c0, 0);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {64'd0, 64'h11};
    cycles(4);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_ignore();
    t_ctx();
    t_tlb_stall();
    t_wait();
    t_wrap();
    t_bad_type();
    t_disable();
    t_zero_scope();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule